// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches two dedicated interrupt pins and a group of pin-change inputs, and turns activity on them into interrupt requests for a processor core. Each dedicated pin has its own two-bit sense field. The field selects one of four triggers: a held low level, any transition, a high-to-low transition or a low-to-high transition. The pin-change group has a per-pin mask, and all of its pins share a single request. Every input passes through a two-flop synchronizer before any detection. Detection looks only at the pin value and ignores whether the pin is driven as an output.

Transition events set sticky pending flags. Software clears a flag by writing one to it, and an acknowledge from the core clears the flag of the source it accepted. Level-sensed requests are never latched: they follow the synchronized pin. A request reaches the core only when its enable bit and the core's global interrupt-enable input are both set.

A small arbiter state machine presents one source at a time on `irq_req`/`irq_vec`. Its states are `ST_IDLE`, `ST_OFFER` and `ST_RETIRE`, with these transitions:
- grant: from `ST_IDLE` to `ST_OFFER` when any source is active. The highest-priority source is latched.
- withdraw: from `ST_OFFER` back to `ST_IDLE` when the latched source stops being active without an acknowledge.
- accept: from `ST_OFFER` to `ST_RETIRE` on `irq_ack`. This also clears that source's flag.
- settle: from `ST_RETIRE` to `ST_IDLE` after one cycle.

Top module: `xpin_irq_ctrl`

## Requirements
- R1: After reset the enable, sense, mask and pending registers read zero, `irq_req` is 0 and `irq_vec` is 0.
- R2: In the enable register (address 0), bit 7 enables dedicated pin 1, bit 6 enables dedicated pin 0 and bit 5 enables the pin-change group. Bits 4..0 always read zero.
- R3: The sense register is at address 1, with pin 0 in bits 1:0 and pin 1 in bits 3:2. Code 10 sets the pin's pending flag on a falling edge only. A low pulse lasting one clock period is detected.
- R4: Code 11 sets the pending flag on a rising edge only. Code 01 sets it on either edge.
- R5: Code 00 raises a request while the synchronized pin is low and the pin is enabled with global enable set. The request drops when the pin returns high, and the pending flag is never set in this mode.
- R6: Pending flags record events whatever the enables are. A request is presented only when the source's enable bit and `gie` are both 1.
- R7: The pin-change mask is at address 2. A transition on a pin whose mask bit is 1 sets the shared pin-change flag. A transition on an unmasked pin has no effect on it.
- R8: The pending register is at address 3, with bit 0 for pin 0, bit 1 for pin 1 and bit 2 for pin-change. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: An `irq_ack` while a request is presented drops `irq_req` on the next cycle and clears the flag of the presented source.
- R10: `irq_vec` is 1 for pin 0, 2 for pin 1 and 3 for pin-change, and 0 when idle. Simultaneous sources are presented in the order pin 0, pin 1, pin-change. The vector is stable while it is presented.
- R11: A write that changes a pin's sense field discards that pin's sample history for one cycle, so an edge seen in that cycle does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_x0 | input | 1 | Dedicated interrupt pin 0 |
| pin_x1 | input | 1 | Dedicated interrupt pin 1 |
| pin_chg | input | PC_WIDTH | Pin-change group inputs |
| gie | input | 1 | Global interrupt enable from the core |
| irq_ack | input | 1 | Core accepts the presented request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 2 | Source code of the presented request |

## Verification
Some properties are checked on every cycle:
- A request only rises after `gie` was high.
- A presented vector is non-zero and holds steady.
- An acknowledge always drops the request.
- The low enable bits read zero.
- Level mode never raises a flag.
- A write-one-to-clear of the pin-change flag clears it.

Other behaviour can only be shown by the bench's scenarios: which transition each sense code responds to, the masking of pin-change inputs, the priority order across successive acknowledges, and the suppressed edge after a sense change.

// File: rtl/xpin_irq_pkg.sv
package xpin_irq_pkg;
    localparam logic [1:0] ADDR_ENABLE = 2'd0;
    localparam logic [1:0] ADDR_SENSE  = 2'd1;
    localparam logic [1:0] ADDR_MASK   = 2'd2;
    localparam logic [1:0] ADDR_PEND   = 2'd3;

    localparam int EN_PIN1_BIT = 7;
    localparam int EN_PIN0_BIT = 6;
    localparam int EN_PCHG_BIT = 5;

    localparam logic [1:0] SENSE_LOW  = 2'b00;
    localparam logic [1:0] SENSE_ANY  = 2'b01;
    localparam logic [1:0] SENSE_FALL = 2'b10;
    localparam logic [1:0] SENSE_RISE = 2'b11;

    localparam logic [1:0] VEC_NONE = 2'd0;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_RETIRE = 2'd2
    } arb_state_t;
endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xpin_sense.sv
module xpin_sense
    import xpin_irq_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp,
    input  logic [1:0] mode,
    input  logic       hist_clr,
    output logic       event_o
);
    logic prev;
    logic hist_ok;
    logic raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev    <= RST_VAL;
            hist_ok <= 1'b1;
        end else begin
            prev    <= smp;
            hist_ok <= !hist_clr;
        end
    end

    always_comb begin
        unique case (mode)
            SENSE_LOW:  raw = 1'b0;
            SENSE_ANY:  raw = smp ^ prev;
            SENSE_FALL: raw = prev & !smp;
            SENSE_RISE: raw = !prev & smp;
            default:    raw = 1'b0;
        endcase
    end

    assign event_o = raw & hist_ok & !hist_clr;
endmodule

// File: rtl/xpin_pchg.sv
module xpin_pchg #(
    parameter int   WIDTH   = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] smp,
    input  logic [WIDTH-1:0] mask,
    output logic             event_o
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= {WIDTH{RST_VAL}};
        else        prev <= smp;
    end

    assign event_o = |((smp ^ prev) & mask);
endmodule

// File: rtl/xpin_arb.sv
module xpin_arb
    import xpin_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] active,
    input  logic               ack,
    output logic               req,
    output logic [1:0]         vec,
    output logic [NUM_SRC-1:0] ack_clr
);
    arb_state_t state, state_nx;
    logic [1:0] cur, cur_nx;
    logic [1:0] pick;

    always_comb begin
        pick = VEC_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) pick = 2'(i + 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= VEC_NONE;
        end else begin
            state <= state_nx;
            cur   <= cur_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cur_nx   = cur;
        unique case (state)
            ST_IDLE: begin
                if (|active) begin
                    state_nx = ST_OFFER;
                    cur_nx   = pick;
                end
            end
            ST_OFFER: begin
                if (ack) begin
                    state_nx = ST_RETIRE;
                end else if (!active[cur - 2'd1]) begin
                    state_nx = ST_IDLE;
                    cur_nx   = VEC_NONE;
                end
            end
            ST_RETIRE: begin
                state_nx = ST_IDLE;
                cur_nx   = VEC_NONE;
            end
            default: begin
                state_nx = ST_IDLE;
                cur_nx   = VEC_NONE;
            end
        endcase
    end

    always_comb begin
        req     = 1'b0;
        vec     = VEC_NONE;
        ack_clr = '0;
        unique case (state)
            ST_IDLE:   ;
            ST_OFFER: begin
                req = 1'b1;
                vec = cur;
                if (ack) ack_clr[cur - 2'd1] = 1'b1;
            end
            ST_RETIRE: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
    import xpin_irq_pkg::*;
#(
    parameter int PC_WIDTH    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_x0,
    input  logic                pin_x1,
    input  logic [PC_WIDTH-1:0] pin_chg,
    input  logic                gie,
    input  logic                irq_ack,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic                irq_req,
    output logic [1:0]          irq_vec
);
    localparam int NUM_PIN = 2;

    logic [NUM_PIN-1:0]  pin_s;
    logic [PC_WIDTH-1:0] chg_s;
    logic [2:0]          en_bits;
    logic [3:0]          sense;
    logic [PC_WIDTH-1:0] pc_mask;
    logic [NUM_SRC-1:0]  pend;
    logic [NUM_SRC-1:0]  pend_set;
    logic [NUM_SRC-1:0]  w1c;
    logic [NUM_SRC-1:0]  ack_clr;
    logic [NUM_SRC-1:0]  active;
    logic [NUM_PIN-1:0]  sense_chg;
    logic [NUM_PIN-1:0]  pin_en;

    xpin_sync #(.WIDTH(NUM_PIN), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .d({pin_x1, pin_x0}), .q(pin_s)
    );

    xpin_sync #(.WIDTH(PC_WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_chg (
        .clk(clk), .rst_n(rst_n), .d(pin_chg), .q(chg_s)
    );

    assign pin_en = {en_bits[2], en_bits[1]};

    generate
        for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
            assign sense_chg[g] = reg_wr && (reg_addr == ADDR_SENSE)
                                  && (reg_wdata[2*g +: 2] != sense[2*g +: 2]);

            xpin_sense #(.RST_VAL(1'b1)) u_sense (
                .clk(clk), .rst_n(rst_n), .smp(pin_s[g]),
                .mode(sense[2*g +: 2]), .hist_clr(sense_chg[g]),
                .event_o(pend_set[g])
            );

            assign active[g] = gie && pin_en[g] &&
                ((sense[2*g +: 2] == SENSE_LOW) ? !pin_s[g] : pend[g]);
        end
    endgenerate

    xpin_pchg #(.WIDTH(PC_WIDTH), .RST_VAL(1'b1)) u_pchg (
        .clk(clk), .rst_n(rst_n), .smp(chg_s), .mask(pc_mask), .event_o(pend_set[2])
    );

    assign active[2] = gie && en_bits[0] && pend[2];

    assign w1c = (reg_wr && reg_addr == ADDR_PEND) ? reg_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_bits <= '0;
            sense   <= '0;
            pc_mask <= '0;
            pend    <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_ENABLE)
                en_bits <= {reg_wdata[EN_PIN1_BIT], reg_wdata[EN_PIN0_BIT], reg_wdata[EN_PCHG_BIT]};
            if (reg_wr && reg_addr == ADDR_SENSE)
                sense <= reg_wdata[3:0];
            if (reg_wr && reg_addr == ADDR_MASK)
                pc_mask <= reg_wdata[PC_WIDTH-1:0];
            pend <= (pend & ~w1c & ~ack_clr) | pend_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_ENABLE: begin
                reg_rdata[EN_PIN1_BIT] = en_bits[2];
                reg_rdata[EN_PIN0_BIT] = en_bits[1];
                reg_rdata[EN_PCHG_BIT] = en_bits[0];
            end
            ADDR_SENSE: reg_rdata[3:0] = sense;
            ADDR_MASK:  reg_rdata[PC_WIDTH-1:0] = pc_mask;
            ADDR_PEND:  reg_rdata[NUM_SRC-1:0] = pend;
            default:    reg_rdata = '0;
        endcase
    end

    xpin_arb u_arb (
        .clk(clk), .rst_n(rst_n), .active(active), .ack(irq_ack),
        .req(irq_req), .vec(irq_vec), .ack_clr(ack_clr)
    );
endmodule

// File: rtl/xpin_irq_checker.sv
module xpin_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       gie,
    input logic       irq_ack,
    input logic       irq_req,
    input logic [1:0] irq_vec,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [3:0] sense,
    input logic [2:0] pend,
    input logic [2:0] pend_set
);
    AST_REQ_AFTER_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie)); // R6

    AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec != 2'd0)); // R10

    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(irq_req)) |-> $stable(irq_vec)); // R10

    AST_EN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[4:0] == 5'd0)); // R2

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[1:0] == 2'b00 && !pend[0]) |=> !pend[0]); // R5

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req); // R9

    AST_W1C_PCHG: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && reg_wdata[2] && !pend_set[2]) |=> !pend[2]); // R8
endmodule

bind xpin_irq_ctrl xpin_irq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .gie(gie), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sense(sense), .pend(pend), .pend_set(pend_set)
);

// File: tb/xpin_irq_ctrl_bench.sv
module xpin_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PCW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pin_x0 = 1'b1;
    logic           pin_x1 = 1'b1;
    logic [PCW-1:0] pin_chg = '1;
    logic           gie = 1'b0;
    logic           irq_ack = 1'b0;
    logic           reg_wr = 1'b0;
    logic [1:0]     reg_addr = 2'd0;
    logic [7:0]     reg_wdata = 8'd0;
    logic [7:0]     reg_rdata;
    logic           irq_req;
    logic [1:0]     irq_vec;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xpin_irq_ctrl #(.PC_WIDTH(PCW)) u_xpin_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_x0(pin_x0), .pin_x1(pin_x1),
        .pin_chg(pin_chg), .gie(gie), .irq_ack(irq_ack), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    typedef struct packed {
        logic       pin;
        logic [1:0] mode;
        logic       from_lv;
        logic       to_lv;
        logic       exp_flag;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t TABLE [NVEC] = '{
        '{1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
        '{1'b0, 2'b10, 1'b0, 1'b1, 1'b0},
        '{1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
        '{1'b0, 2'b11, 1'b1, 1'b0, 1'b0},
        '{1'b0, 2'b01, 1'b1, 1'b0, 1'b1},
        '{1'b0, 2'b01, 1'b0, 1'b1, 1'b1},
        '{1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
        '{1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
        '{1'b1, 2'b11, 1'b1, 1'b0, 1'b0},
        '{1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
        '{1'b1, 2'b01, 1'b0, 1'b1, 1'b1},
        '{1'b1, 2'b00, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pin(input logic p, input logic v);
        if (p) pin_x1 = v; else pin_x0 = v;
    endtask

    task automatic do_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, d); check("R1 enable", d, 8'h00);
        rd(2'd1, d); check("R1 sense", d, 8'h00);
        rd(2'd2, d); check("R1 mask", d, 8'h00);
        rd(2'd3, d); check("R1 pending", d, 8'h00);
        check("R1 req", {7'd0, irq_req}, 8'd0);
        check("R1 vec", {6'd0, irq_vec}, 8'd0);

        // R3 R4 R5 table walk, enables off
        for (int k = 0; k < NVEC; k++) begin
            wr(2'd1, TABLE[k].pin ? {4'd0, TABLE[k].mode, 2'b00} : {6'd0, TABLE[k].mode});
            set_pin(TABLE[k].pin, TABLE[k].from_lv);
            idle(6);
            wr(2'd3, 8'h07);
            set_pin(TABLE[k].pin, TABLE[k].to_lv);
            idle(6);
            rd(2'd3, d);
            check($sformatf("R3/R4/R5 vector %0d", k), {7'd0, d[TABLE[k].pin]},
                  {7'd0, TABLE[k].exp_flag});
        end
        pin_x0 = 1'b1; pin_x1 = 1'b1;
        idle(6);
        wr(2'd3, 8'h07);

        // R2 enable layout
        wr(2'd0, 8'hFF);
        rd(2'd0, d); check("R2 enable readback", d, 8'hE0);
        wr(2'd0, 8'h00);

        // R3 one-cycle low pulse in falling mode
        wr(2'd1, 8'h02);
        idle(3);
        @(negedge clk); pin_x0 = 1'b0;
        @(negedge clk); pin_x0 = 1'b1;
        idle(5);
        rd(2'd3, d); check("R3 short pulse", d, 8'h01);

        // R8 write zero keeps, write one clears
        wr(2'd3, 8'h00);
        rd(2'd3, d); check("R8 write zero", d, 8'h01);
        wr(2'd3, 8'h01);
        rd(2'd3, d); check("R8 write one", d, 8'h00);

        // R6 flag recorded with enable off, no request
        @(negedge clk); pin_x0 = 1'b0;
        idle(6);
        gie = 1'b1;
        idle(3);
        check("R6 no req without enable", {7'd0, irq_req}, 8'd0);
        gie = 1'b0;
        wr(2'd0, 8'h40);
        idle(3);
        check("R6 no req without gie", {7'd0, irq_req}, 8'd0);
        gie = 1'b1;
        idle(3);
        check("R6 req when both set", {7'd0, irq_req}, 8'd1);
        check("R10 vec pin0", {6'd0, irq_vec}, 8'd1);

        // R9 ack clears flag and drops request
        do_ack();
        check("R9 req dropped", {7'd0, irq_req}, 8'd0);
        rd(2'd3, d); check("R9 flag cleared", d, 8'h00);
        idle(3);
        check("R9 stays idle", {7'd0, irq_req}, 8'd0);

        // R5 level mode request follows pin
        pin_x0 = 1'b1;
        wr(2'd1, 8'h00);
        idle(6);
        check("R5 high no req", {7'd0, irq_req}, 8'd0);
        @(negedge clk); pin_x0 = 1'b0;
        idle(6);
        check("R5 low req", {7'd0, irq_req}, 8'd1);
        rd(2'd3, d); check("R5 no flag", d, 8'h00);
        @(negedge clk); pin_x0 = 1'b1;
        idle(6);
        check("R5 release", {7'd0, irq_req}, 8'd0);

        // R7 pin-change masking
        gie = 1'b0;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h08);
        @(negedge clk); pin_chg[2] = 1'b0;
        idle(6);
        rd(2'd3, d); check("R7 unmasked ignored", d, 8'h00);
        @(negedge clk); pin_chg[3] = 1'b0;
        idle(6);
        rd(2'd3, d); check("R7 masked sets flag", d, 8'h04);
        wr(2'd3, 8'h07);

        // R10 priority across three sources
        wr(2'd1, 8'h0A);
        wr(2'd2, 8'h01);
        idle(3);
        @(negedge clk); pin_x0 = 1'b0; pin_x1 = 1'b0; pin_chg[0] = 1'b0;
        idle(6);
        rd(2'd3, d); check("R10 all pending", d, 8'h07);
        wr(2'd0, 8'hE0);
        gie = 1'b1;
        idle(3);
        check("R10 first vec", {6'd0, irq_vec}, 8'd1);
        do_ack();
        idle(3);
        check("R10 second vec", {6'd0, irq_vec}, 8'd2);
        do_ack();
        idle(3);
        check("R10 third vec", {6'd0, irq_vec}, 8'd3);
        do_ack();
        idle(3);
        check("R10 idle vec", {6'd0, irq_vec}, 8'd0);
        check("R10 idle req", {7'd0, irq_req}, 8'd0);

        // R11 sense change suppresses coincident edge
        gie = 1'b0;
        pin_x0 = 1'b1;
        wr(2'd1, 8'h03);
        idle(6);
        wr(2'd3, 8'h07);
        @(negedge clk); pin_x0 = 1'b0;
        wr(2'd1, 8'h02);
        idle(5);
        rd(2'd3, d); check("R11 no false edge", {7'd0, d[0]}, 8'd0);
        @(negedge clk); pin_x0 = 1'b1;
        idle(4);
        @(negedge clk); pin_x0 = 1'b0;
        idle(6);
        rd(2'd3, d); check("R11 later edge seen", {7'd0, d[0]}, 8'd1);

        done = 1'b1;
        finish_run();
    end
endmodule